// File: doc/BRIEF.md
# Burst Column Address Sequencer

This block turns one accepted burst request into the list of column addresses that the burst touches, one address per clock cycle. The request carries the first column, a length selector (four or eight beats) and an order selector (sequential or interleaved). The block registers all three when it accepts the request. From the next cycle on it drives a valid flag and the current column, and it raises a last flag on the final beat.

Every address of a burst stays inside the aligned group of columns that holds the first column. The group is four columns wide for short bursts and eight columns wide for long bursts. The low bits of the first column set where the walk starts inside the group. Sequential order steps the low two bits up and wraps them modulo four. In a long burst it then repeats the same four-step walk in the other half of the group. Interleaved order forms each offset as the start offset XOR the beat number.

The controller has two states. IDLE waits for a request. RUN emits beats. There are three transitions. ACCEPT goes from IDLE to RUN on a start strobe. STEP stays in RUN while beats remain. FINISH goes from RUN back to IDLE after the final beat. A start strobe is taken only in IDLE, so every burst is followed by at least one idle cycle.

Top module: `burst_colseq`

## Requirements
- R1: While rst_n is low, and in the first cycle after it rises, valid_o and last_o are 0, even if start_i is high.
- R2: A start_i sampled high in IDLE gives valid_o = 1 on the next cycle, with col_o equal to the sampled col_i. With no start strobe, valid_o stays 0.
- R3: A burst holds valid_o high for exactly 4 consecutive cycles when long_i = 0 and exactly 8 when long_i = 1. valid_o is 0 in the cycle after the last beat.
- R4: When long_i = 0 and ilv_i = 0, beat i has col_o[1:0] = (start[1:0] + i) mod 4.
- R5: When long_i = 1 and ilv_i = 0, beat i has col_o[1:0] = (start[1:0] + i) mod 4 and col_o[2] = start[2] XOR (i >= 4).
- R6: When ilv_i = 1, beat i has its low offset bits (two bits for 4 beats, three bits for 8 beats) equal to the start offset XOR i.
- R7: last_o is 1 on the final beat of a burst and 0 on every other cycle.
- R8: While a burst is running, start_i and any change to col_i, long_i or ilv_i have no effect. The running sequence goes on unchanged, and no extra burst follows it.
- R9: During a burst, the col_o bits above the offset (bit 2 and up for 4 beats, bit 3 and up for 8 beats) equal the same bits of the start column.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Burst request strobe, taken only in IDLE |
| col_i | input | COL_W | First column of the burst |
| long_i | input | 1 | Length select: 0 = 4 beats, 1 = 8 beats |
| ilv_i | input | 1 | Order select: 0 = sequential, 1 = interleaved |
| valid_o | output | 1 | col_o holds a beat address |
| last_o | output | 1 | Current beat is the final one |
| col_o | output | COL_W | Column address of the current beat |

## Verification
The hardest situation to create from the ports is a new request that arrives while a burst is running. The stimulus holds start_i high through the middle of a burst and, at the same time, inverts col_i and flips both selectors. It then checks every remaining beat against the original request and confirms that no burst follows. Start columns at the very top of the address range, together with start offsets 3, 6 and 7, force the wrap back to the bottom of the group. Those cases show that no carry leaks into the upper bits.

// File: rtl/burst_pkg.sv
package burst_pkg;

    localparam int BEAT_W    = 3;
    localparam int SHORT_LEN = 4;
    localparam int LONG_LEN  = 8;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } burst_state_t;

endpackage

// File: rtl/burst_ctrl.sv
module burst_ctrl
    import burst_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              long_i,
    output logic              accept_o,
    output logic              run_o,
    output logic              last_o,
    output logic [BEAT_W-1:0] beat_o
);

    localparam logic [BEAT_W-1:0] END_SHORT = BEAT_W'(SHORT_LEN - 1);
    localparam logic [BEAT_W-1:0] END_LONG  = BEAT_W'(LONG_LEN - 1);

    burst_state_t      state_q, state_d;
    logic [BEAT_W-1:0] beat_q;
    logic              long_q;
    logic [BEAT_W-1:0] end_beat;
    logic              at_end;

    assign end_beat = long_q ? END_LONG : END_SHORT;
    assign at_end   = (beat_q == end_beat);

    // next state: ACCEPT, STEP, FINISH
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start_i) state_d = ST_RUN;
            ST_RUN:  if (at_end)  state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // state register with beat counter and latched length
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            beat_q  <= '0;
            long_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            if (accept_o) begin
                beat_q <= '0;
                long_q <= long_i;
            end else if (run_o && !at_end) begin
                beat_q <= beat_q + 1'b1;
            end
        end
    end

    // outputs
    always_comb begin
        accept_o = (state_q == ST_IDLE) && start_i;
        run_o    = (state_q == ST_RUN);
        last_o   = run_o && at_end;
        beat_o   = beat_q;
    end

    AST_BEAT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        run_o |-> (beat_q <= end_beat)); // R3
    AST_LAST_ENDS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        last_o |=> !run_o); // R3
    AST_ACCEPT_BEGINS: assert property (@(posedge clk) disable iff (!rst_n)
        accept_o |=> (run_o && beat_q == '0)); // R2
    AST_BUSY_STEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (run_o && !last_o) |=> (run_o && beat_q == BEAT_W'($past(beat_q) + 1'b1))); // R8

endmodule

// File: rtl/burst_offset.sv
module burst_offset
    import burst_pkg::*;
(
    input  logic [BEAT_W-1:0] start_off_i,
    input  logic [BEAT_W-1:0] beat_i,
    input  logic              ilv_i,
    output logic [BEAT_W-1:0] off_o
);

    logic [1:0] nib_low;
    logic       half_sel;

    // A 4-beat burst never reaches beat 4, so bit 2 stays at the start value.
    always_comb begin
        nib_low  = start_off_i[1:0] + beat_i[1:0];
        half_sel = start_off_i[2] ^ beat_i[2];
        if (ilv_i) off_o = start_off_i ^ beat_i;
        else       off_o = {half_sel, nib_low};
    end

endmodule

// File: rtl/burst_colseq.sv
module burst_colseq
    import burst_pkg::*;
#(
    parameter int COL_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [COL_W-1:0] col_i,
    input  logic             long_i,
    input  logic             ilv_i,
    output logic             valid_o,
    output logic             last_o,
    output logic [COL_W-1:0] col_o
);

    localparam int HI_W = COL_W - BEAT_W;

    logic              accept;
    logic              run;
    logic              last;
    logic [BEAT_W-1:0] beat;
    logic [BEAT_W-1:0] off;
    logic [COL_W-1:0]  col_q;
    logic              ilv_q;

    burst_ctrl u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (start_i),
        .long_i   (long_i),
        .accept_o (accept),
        .run_o    (run),
        .last_o   (last),
        .beat_o   (beat)
    );

    burst_offset u_off (
        .start_off_i (col_q[BEAT_W-1:0]),
        .beat_i      (beat),
        .ilv_i       (ilv_q),
        .off_o       (off)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            col_q <= '0;
            ilv_q <= 1'b0;
        end else if (accept) begin
            col_q <= col_i;
            ilv_q <= ilv_i;
        end
    end

    always_comb begin
        valid_o = run;
        last_o  = last;
        col_o   = {col_q[COL_W-1:BEAT_W], off};
    end

    AST_FIRST_IS_START: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> (valid_o && col_o == $past(col_i))); // R2
    AST_UPPER_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && $past(valid_o)) |-> (col_o[COL_W-1:BEAT_W] == $past(col_o[COL_W-1:BEAT_W]))); // R9
    AST_LAST_IS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        last_o |-> valid_o); // R7

    initial begin
        AST_COL_WIDE_ENOUGH: assert (HI_W >= 1); // R9
    end

endmodule

// File: tb/burst_colseq_tb_top.sv
module burst_colseq_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int COL_W      = 10;

    // {long, ilv, col[9:0]}
    localparam logic [11:0] VEC [8] = '{
        {1'b0, 1'b0, 10'h000},
        {1'b0, 1'b0, 10'h3FF},
        {1'b0, 1'b1, 10'h0A6},
        {1'b1, 1'b0, 10'h125},
        {1'b1, 1'b0, 10'h040},
        {1'b1, 1'b1, 10'h2CE},
        {1'b1, 1'b1, 10'h3FB},
        {1'b1, 1'b0, 10'h3FF}
    };

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start_i = 1'b0;
    logic [COL_W-1:0] col_i = '0;
    logic             long_i = 1'b0;
    logic             ilv_i = 1'b0;
    logic             valid_o;
    logic             last_o;
    logic [COL_W-1:0] col_o;

    int n_total = 0;
    int n_bad   = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    burst_colseq #(.COL_W(COL_W)) dut_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (start_i),
        .col_i   (col_i),
        .long_i  (long_i),
        .ilv_i   (ilv_i),
        .valid_o (valid_o),
        .last_o  (last_o),
        .col_o   (col_o)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_total++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic int exp_col(input int col, input bit lng, input bit ilv, input int i);
        int n, s, base, off;
        n    = lng ? 8 : 4;
        s    = col % n;
        base = col - s;
        if (ilv)       off = s ^ i;
        else if (!lng) off = ((s % 4) + i) % 4;
        else           off = ((s % 4) + i) % 4 + 4 * (((s / 4) + (i / 4)) % 2);
        return base + off;
    endfunction

    task automatic run_burst(input logic [COL_W-1:0] col, input bit lng, input bit ilv,
                             input bit disturb);
        int    n;
        string rq;
        n  = lng ? 8 : 4;
        rq = ilv ? "R6" : (lng ? "R5" : "R4");
        @(negedge clk);
        start_i = 1'b1; col_i = col; long_i = lng; ilv_i = ilv;
        @(negedge clk);
        start_i = 1'b0;
        for (int i = 0; i < n; i++) begin
            check(valid_o === 1'b1, "R3 valid during burst", int'(valid_o), 1);
            if (i == 0)
                check(col_o === col, "R2 first beat", int'(col_o), int'(col));
            check(int'(col_o) == exp_col(int'(col), lng, ilv, i),
                  disturb ? "R8 order under disturbance" : rq,
                  int'(col_o), exp_col(int'(col), lng, ilv, i));
            check((int'(col_o) / n) == (int'(col) / n), "R9 upper bits",
                  int'(col_o) / n, int'(col) / n);
            check(last_o === (i == n - 1), "R7 last flag", int'(last_o), int'(i == n - 1));
            if (disturb && i < n - 1) begin
                start_i = 1'b1; col_i = ~col; long_i = ~lng; ilv_i = ~ilv;
            end else begin
                start_i = 1'b0;
            end
            @(negedge clk);
        end
        check(valid_o === 1'b0, disturb ? "R8 no extra burst" : "R3 end of burst",
              int'(valid_o), 0);
        check(last_o === 1'b0, "R7 last low after burst", int'(last_o), 0);
        @(negedge clk);
        check(valid_o === 1'b0, disturb ? "R8 still idle" : "R2 idle without start",
              int'(valid_o), 0);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_total++;
        n_bad++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("  test done: total=%0d bad=%0d", n_total, n_bad);
        $finish;
    end

    initial begin
        // R1: reset holds outputs low even with a request pending
        start_i = 1'b1; col_i = 10'h155; long_i = 1'b1;
        repeat (3) begin
            @(negedge clk);
            check(valid_o === 1'b0, "R1 valid in reset", int'(valid_o), 0);
            check(last_o === 1'b0, "R1 last in reset", int'(last_o), 0);
        end
        start_i = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);
        check(valid_o === 1'b0, "R1 valid after reset", int'(valid_o), 0);
        repeat (3) @(negedge clk);
        check(valid_o === 1'b0, "R2 no start no burst", int'(valid_o), 0);

        foreach (VEC[k])
            run_burst(VEC[k][9:0], VEC[k][11], VEC[k][10], 1'b0);

        // R8: request and new settings during running bursts
        run_burst(10'h2B5, 1'b1, 1'b0, 1'b1);
        run_burst(10'h1C3, 1'b0, 1'b1, 1'b1);
        run_burst(10'h00E, 1'b0, 1'b0, 1'b1);

        // corner cases: every start offset of each kind
        for (int s = 0; s < 8; s++) run_burst(COL_W'(10'h3F8 + s), 1'b1, 1'b0, 1'b0);
        for (int s = 0; s < 8; s++) run_burst(COL_W'(10'h3F8 + s), 1'b1, 1'b1, 1'b0);
        for (int s = 0; s < 4; s++) run_burst(COL_W'(10'h3FC + s), 1'b0, 1'b0, 1'b0);
        for (int s = 0; s < 4; s++) run_burst(COL_W'(10'h010 + s), 1'b0, 1'b1, 1'b0);

        $display("  test done: total=%0d bad=%0d", n_total, n_bad);
        $finish;
    end

endmodule